// File: doc/BRIEF.md
# Ethernet receive preamble capture

This block sits beside a byte-wide receive path (a valid flag plus an 8-bit data byte per clock) and keeps the octets that arrive before the start-of-frame delimiter. The delimiter value 0xD5 ends the preamble. When it is seen, the block presents an 8-byte record of the captured octets with a single-cycle strobe. The strobe comes before any payload byte of the same frame could be processed downstream.

The newest octet before the delimiter always lands in slot 6. Older octets sit in the lower slots. A preamble shorter than seven octets leaves the leading slots empty, and these are driven as zero. A preamble longer than seven octets keeps only its last seven. When the reduced-pin mode input is high, capture is switched off entirely.

Top module: `rx_preamble_grab`

## Requirements
- R1: A byte of value 0xD5 sampled with `rx_dv` high, while the frame is still in its preamble, ends the preamble and is never stored. `rec_valid` is high for exactly the one cycle after the clock edge that sampled it.
- R2: Record layout: byte k of the record is `rec_data[8k+7:8k]`. Bytes 0 to 6 hold preamble slots 0 to 6. Byte 7 (`rec_data[63:56]`) is reserved and always zero while `rec_valid` is high.
- R3: When exactly seven preamble octets precede the delimiter, slot 0 holds the first one received and slot 6 the seventh.
- R4: When n < 7 octets precede the delimiter, they fill slots 7-n through 6 in arrival order, and slots 0 through 6-n read zero.
- R5: When more than seven octets precede the delimiter, only the last seven are kept: slot 6 holds the octet just before the delimiter, and earlier octets are shifted out.
- R6: If `rx_dv` falls before any delimiter is seen, no strobe is issued. The next frame's record contains none of the discarded octets.
- R7: After the delimiter, every further byte of the same frame is ignored, including further 0xD5 bytes, until `rx_dv` falls. No second strobe follows and the presented record is unchanged.
- R8: While `rmii_mode` is high, no strobe is produced. A frame in which any byte is sampled with `rmii_mode` high produces no strobe, even if the mode drops before its delimiter.
- R9: Synchronous active-high `rst` clears the capture, the octet count and the outputs: `rec_valid` = 0 and `rec_data` = 0.
- R10: A delimiter that arrives as the first byte of a frame still produces a strobe, with an all-zero record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rmii_mode | input | 1 | High selects reduced-pin operation; capture is disabled |
| rx_dv | input | 1 | Receive data valid |
| rx_byte | input | 8 | Receive data byte |
| rec_valid | output | 1 | One-cycle strobe: record is ready |
| rec_data | output | 64 | Captured preamble record, byte k at bits 8k+7:8k |

## Verification
Several situations are hard to reach from the ports. One is a preamble longer than seven octets, where older octets must fall out of the record. Another is a 0xD5 byte that appears after the delimiter, which must not restart capture. A third is a frame aborted before its delimiter, which must leave no residue in the next record. The bench drives whole frames of chosen preamble length, each built from a counting byte pattern, so that every slot of the record tells which received octet it came from. A frame of ten octets shows the shift-out. Payloads containing 0xD5 probe the post-delimiter state. An aborted frame of distinctive bytes is followed by a short frame whose zero slots must stay clean. The reduced-pin mode is raised for a single byte in mid-frame to show that the abandoned state lasts until `rx_dv` falls.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

   // Per-frame progress of the capture engine
   typedef enum logic [1:0] {
      PH_HUNT    = 2'd0,   // collecting preamble, watching for delimiter
      PH_PAYLOAD = 2'd1,   // delimiter seen, rest of frame ignored
      PH_SKIP    = 2'd2    // frame abandoned (mode change), wait for idle
   } rxp_phase_e;

   // Number of bits for a saturating count up to lim
   function automatic int cnt_bits(input int lim);
      int b;
      b = 1;
      while ((1 << b) <= lim) b++;
      return b;
   endfunction

endpackage

// File: rtl/rxp_sfd_match.sv
// Delimiter comparator. MATCH_MASK lets a variant ignore some bits.
module rxp_sfd_match #(
   parameter int                 BYTE_W     = 8,
   parameter logic [BYTE_W-1:0]  SFD_VAL    = 8'hD5,
   parameter logic [BYTE_W-1:0]  MATCH_MASK = '1
) (
   input  logic [BYTE_W-1:0] byte_in,
   output logic              is_sfd
);
   generate
      if (MATCH_MASK == {BYTE_W{1'b1}}) begin : g_exact
         assign is_sfd = (byte_in == SFD_VAL);
      end else begin : g_masked
         assign is_sfd = ((byte_in & MATCH_MASK) == (SFD_VAL & MATCH_MASK));
      end
   endgenerate
endmodule

// File: rtl/rxp_octet_shifter.sv
// Slot SLOTS-1 takes the newest octet; older octets move toward slot 0.
module rxp_octet_shifter #(
   parameter int BYTE_W = 8,
   parameter int SLOTS  = 7
) (
   input  logic                    clk,
   input  logic                    clr,
   input  logic                    shift_en,
   input  logic [BYTE_W-1:0]       din,
   output logic [SLOTS*BYTE_W-1:0] slots_flat
);
   logic [BYTE_W-1:0] slot_q [SLOTS];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic [BYTE_W-1:0] feed;
         if (s == SLOTS - 1) begin : g_top
            assign feed = din;
         end else begin : g_mid
            assign feed = slot_q[s+1];
         end
         always_ff @(posedge clk) begin
            if (clr)           slot_q[s] <= '0;
            else if (shift_en) slot_q[s] <= feed;
         end
         assign slots_flat[s*BYTE_W +: BYTE_W] = slot_q[s];
      end
   endgenerate
endmodule

// File: rtl/rxp_fill_counter.sv
// Saturating count of preamble octets taken in the current frame.
module rxp_fill_counter #(
   parameter int LIMIT = 7,
   parameter int CW    = rxp_pkg::cnt_bits(LIMIT)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   always_ff @(posedge clk) begin
      if (clr)                     count <= '0;
      else if (inc && count != LIM_V) count <= count + 1'b1;
   end
endmodule

// File: rtl/rxp_record_pack.sv
// Builds the record: slots not yet filled and the reserved tail are zero.
module rxp_record_pack #(
   parameter int BYTE_W    = 8,
   parameter int SLOTS     = 7,
   parameter int REC_BYTES = 8,
   parameter int CW        = rxp_pkg::cnt_bits(SLOTS)
) (
   input  logic [SLOTS*BYTE_W-1:0]     slots_flat,
   input  logic [CW-1:0]               count,
   output logic [REC_BYTES*BYTE_W-1:0] record
);
   generate
      for (genvar k = 0; k < REC_BYTES; k++) begin : g_byte
         if (k < SLOTS) begin : g_pre
            logic filled;
            assign filled = (k + int'(count)) >= SLOTS;
            assign record[k*BYTE_W +: BYTE_W] =
               filled ? slots_flat[k*BYTE_W +: BYTE_W] : '0;
         end else begin : g_rsvd
            assign record[k*BYTE_W +: BYTE_W] = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/rx_preamble_grab.sv
module rx_preamble_grab #(
   parameter int                BYTE_W    = 8,
   parameter int                SLOTS     = 7,
   parameter int                REC_BYTES = 8,
   parameter logic [BYTE_W-1:0] SFD_VAL   = 8'hD5,
   parameter int                REC_W     = REC_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rmii_mode,
   input  logic              rx_dv,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              rec_valid,
   output logic [REC_W-1:0]  rec_data
);
   import rxp_pkg::*;

   localparam int CW = cnt_bits(SLOTS);

   generate
      if (SLOTS < 1) begin : g_chk_slots
         $error("SLOTS must be at least 1");
      end
      if (REC_BYTES <= SLOTS) begin : g_chk_rec
         $error("REC_BYTES must exceed SLOTS");
      end
      if (REC_W != REC_BYTES * BYTE_W) begin : g_chk_w
         $error("REC_W must equal REC_BYTES*BYTE_W");
      end
   endgenerate

   rxp_phase_e        phase_q;
   logic              is_sfd;
   logic              hunting;
   logic              sfd_hit;
   logic              take_octet;
   logic              cap_clr;
   logic [SLOTS*BYTE_W-1:0] slots_flat;
   logic [CW-1:0]     fill_cnt;
   logic [REC_W-1:0]  record_w;

   rxp_sfd_match #(.BYTE_W(BYTE_W), .SFD_VAL(SFD_VAL)) u_match (
      .byte_in (rx_byte),
      .is_sfd  (is_sfd)
   );

   assign hunting    = rx_dv && !rmii_mode && (phase_q == PH_HUNT);
   assign sfd_hit    = hunting && is_sfd;
   assign take_octet = hunting && !is_sfd;
   assign cap_clr    = rst || !rx_dv || rmii_mode;

   always_ff @(posedge clk) begin
      if (rst || !rx_dv)  phase_q <= PH_HUNT;
      else if (rmii_mode) phase_q <= PH_SKIP;
      else if (sfd_hit)   phase_q <= PH_PAYLOAD;
   end

   rxp_octet_shifter #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_shift (
      .clk        (clk),
      .clr        (cap_clr),
      .shift_en   (take_octet),
      .din        (rx_byte),
      .slots_flat (slots_flat)
   );

   rxp_fill_counter #(.LIMIT(SLOTS), .CW(CW)) u_cnt (
      .clk   (clk),
      .clr   (cap_clr),
      .inc   (take_octet),
      .count (fill_cnt)
   );

   rxp_record_pack #(.BYTE_W(BYTE_W), .SLOTS(SLOTS), .REC_BYTES(REC_BYTES), .CW(CW)) u_pack (
      .slots_flat (slots_flat),
      .count      (fill_cnt),
      .record     (record_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rec_valid <= 1'b0;
         rec_data  <= '0;
      end else begin
         rec_valid <= sfd_hit;
         if (sfd_hit) rec_data <= record_w;
      end
   end
endmodule

// File: rtl/rxp_checker.sv
module rxp_checker #(
   parameter int                BYTE_W  = 8,
   parameter int                REC_W   = 64,
   parameter logic [BYTE_W-1:0] SFD_VAL = 8'hD5
) (
   input logic              clk,
   input logic              rst,
   input logic              rmii_mode,
   input logic              rx_dv,
   input logic [BYTE_W-1:0] rx_byte,
   input logic              rec_valid,
   input logic [REC_W-1:0]  rec_data
);
   // R1: a strobe is always caused by a delimiter byte on the prior edge
   a_r1_strobe_after_sfd: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> $past(rx_dv && rx_byte == SFD_VAL));

   // R1, R7: the strobe never lasts two cycles
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
      rec_valid |=> !rec_valid);

   // R2: reserved byte reads zero when presented
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> rec_data[REC_W-1 -: BYTE_W] == '0);

   // R8: no strobe from a byte sampled in reduced-pin mode
   a_r8_no_strobe_rmii: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> $past(!rmii_mode));

   // R7: record stays put between strobes
   a_r7_record_stable: assert property (@(posedge clk) disable iff (rst)
      (!rec_valid && !$past(rst)) |-> $stable(rec_data));
endmodule

bind rx_preamble_grab rxp_checker #(
   .BYTE_W (BYTE_W),
   .REC_W  (REC_W),
   .SFD_VAL(SFD_VAL)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .rmii_mode (rmii_mode),
   .rx_dv     (rx_dv),
   .rx_byte   (rx_byte),
   .rec_valid (rec_valid),
   .rec_data  (rec_data)
);

// File: tb/rx_preamble_grab_tb_top.sv
`timescale 1ns/1ps
module rx_preamble_grab_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        rmii_mode;
   logic        rx_dv;
   logic [7:0]  rx_byte;
   logic        rec_valid;
   logic [63:0] rec_data;

   int total = 0;
   int bad   = 0;
   int strobes = 0;
   logic [63:0] last_rec = '0;

   always #5 clk = ~clk;

   rx_preamble_grab dut_i (
      .clk(clk), .rst(rst), .rmii_mode(rmii_mode), .rx_dv(rx_dv),
      .rx_byte(rx_byte), .rec_valid(rec_valid), .rec_data(rec_data)
   );

   // Monitor away from the active edge
   always @(negedge clk) begin
      if (rec_valid) begin
         strobes++;
         last_rec = rec_data;
      end
   end

   // Vector table: preamble length and first byte of a counting pattern
   localparam int NV = 6;
   localparam int          V_LEN  [NV] = '{7, 3, 10, 1, 0, 6};
   localparam logic [7:0]  V_BASE [NV] = '{8'h10, 8'h55, 8'hA0, 8'h01, 8'h30, 8'h70};
   localparam string       V_REQ  [NV] = '{"R3", "R4", "R5", "R4", "R10", "R4"};

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] expect_rec(input int n, input logic [7:0] base);
      logic [63:0] r;
      r = '0;
      for (int s = 0; s < 7; s++) begin
         int j;
         j = n - 7 + s;
         if (j >= 0) r[s*8 +: 8] = base + 8'(j);
      end
      return r;
   endfunction

   task automatic put(input logic dv, input logic [7:0] b);
      @(negedge clk);
      rx_dv   = dv;
      rx_byte = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) put(1'b0, 8'h00);
   endtask

   // preamble of n counting bytes, delimiter, then payload
   task automatic frame(input int n, input logic [7:0] base, input bit with_sfd,
                        input int pay);
      for (int i = 0; i < n; i++) put(1'b1, base + 8'(i));
      if (with_sfd) put(1'b1, 8'hD5);
      for (int i = 0; i < pay; i++) put(1'b1, (i % 2 == 0) ? 8'hD5 : 8'h3C);
      idle(3);
   endtask

   initial begin
      int s0;
      rst = 1'b1; rmii_mode = 1'b0; rx_dv = 1'b0; rx_byte = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", {63'b0, rec_valid}, 64'd0);
      check("R9", rec_data, 64'd0);
      rst = 1'b0;
      idle(2);

      // Table-driven frames
      for (int v = 0; v < NV; v++) begin
         s0 = strobes;
         frame(V_LEN[v], V_BASE[v], 1'b1, 4);
         check(V_REQ[v], 64'(strobes - s0), 64'd1);
         check(V_REQ[v], last_rec, expect_rec(V_LEN[v], V_BASE[v]));
         check("R2", {56'b0, last_rec[63:56]}, 64'd0);
      end

      // R1: strobe timing and width
      put(1'b1, 8'h55); put(1'b1, 8'h56);
      put(1'b1, 8'hD5);
      @(negedge clk);
      rx_byte = 8'h11;
      check("R1", {63'b0, rec_valid}, 64'd1);
      @(negedge clk);
      check("R1", {63'b0, rec_valid}, 64'd0);
      idle(3);

      // R7: bytes after delimiter ignored, incl. more delimiters
      s0 = strobes;
      frame(2, 8'h40, 1'b1, 9);
      check("R7", 64'(strobes - s0), 64'd1);
      check("R7", last_rec, expect_rec(2, 8'h40));

      // R6: aborted frame, then short frame must have clean leading slots
      s0 = strobes;
      frame(6, 8'hE0, 1'b0, 0);
      check("R6", 64'(strobes - s0), 64'd0);
      frame(2, 8'h20, 1'b1, 1);
      check("R6", 64'(strobes - s0), 64'd1);
      check("R6", last_rec, expect_rec(2, 8'h20));

      // R8: mode held high for a whole frame
      s0 = strobes;
      rmii_mode = 1'b1;
      frame(7, 8'h10, 1'b1, 2);
      check("R8", 64'(strobes - s0), 64'd0);
      check("R8", last_rec, expect_rec(2, 8'h20));
      // R8: mode high for one byte mid-frame abandons the frame
      rmii_mode = 1'b0;
      put(1'b1, 8'h61);
      @(negedge clk); rmii_mode = 1'b1; rx_byte = 8'h62;
      @(negedge clk); rmii_mode = 1'b0; rx_byte = 8'h63;
      put(1'b1, 8'hD5); put(1'b1, 8'h00);
      idle(3);
      check("R8", 64'(strobes - s0), 64'd0);
      // normal frame afterwards works again
      frame(4, 8'h80, 1'b1, 1);
      check("R8", 64'(strobes - s0), 64'd1);
      check("R8", last_rec, expect_rec(4, 8'h80));

      // R9: reset mid-preamble clears capture and outputs
      put(1'b1, 8'h91); put(1'b1, 8'h92);
      @(negedge clk); rst = 1'b1; rx_byte = 8'h93;
      @(negedge clk); rst = 1'b0; rx_dv = 1'b0;
      check("R9", rec_data, 64'd0);
      check("R9", {63'b0, rec_valid}, 64'd0);
      idle(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule